// File: doc/BRIEF.md
# Secure-Banked Private Interrupt Register File

This block is the per-processor register file for 32 private interrupt lines. It stores, for every line, a group bit, an enable bit, a pending latch, an active bit, an 8-bit priority, an edge/level trigger flag and a group-modifier bit. It also holds a non-secure-access control word and a sleep handshake bit. Software reaches all of it over a single-cycle register bus. Each access carries a secure flag. While security is enabled, a non-secure access sees and changes only the lines whose group bit is 1.

The enable, effective pending, active, priority and edge-configuration vectors leave the block as flat outputs for a separate prioritisation block. The block also watches the raw interrupt input levels. A level-triggered line shows as pending while its input is high. A rising input on an edge-triggered line sets its pending latch.

Register byte offsets: 0x00 sleep, 0x04 group, 0x08/0x0C enable set/clear, 0x10/0x14 pending set/clear, 0x18/0x1C active set/clear, 0x20..0x3F priority, 0x40/0x44 trigger configuration, 0x48 group modifier, 0x4C non-secure access control. Every other offset is reserved.

Top module: `priv_irq_regfile`

## Requirements
- R1: After reset, all state reads as zero. Lines 0..15 are fixed edge-triggered, so `edge_vec` resets to 0x0000FFFF. `pend_vec` is 0 while all inputs are low, and `bus_rdata` is 0.
- R2: When `sec_disable`=0 and `bus_secure`=0, the bit of any line whose group bit is 0 reads as 0 and ignores writes. This applies to the enable, pending, active, priority and trigger registers. When `sec_disable`=1, every line is visible to every access.
- R3: A write to a set offset ORs the masked write data into the state. A write to a clear offset clears the masked bits. A read of either offset returns the same masked state.
- R4: A pending read, and `pend_vec`, give the pending latch ORed with the live input level of each level-triggered line (edge flag 0).
- R5: A 0-to-1 change of `irq_level[i]` on an edge-triggered line sets pending latch i. The latch stays set after the input falls, until a pending-clear write removes it.
- R6: A restricted (non-secure, security enabled) access to the priority of a group-1 line reads the stored value as (p<<1)&0xFF. A write from such an access stores 0x80|(v>>1). The priority of a group-0 line reads 0 and ignores writes from such an access.
- R7: The priority of line n sits at byte offset 0x20+n. A word access at 0x20+4k covers lines 4k..4k+3, with line 4k in bits 7:0. A byte access at any other offset reads 0 and writes nothing.
- R8: At 0x40 and 0x44, odd bit 2j+1 is the edge flag of line j (0x40) or line 16+j (0x44), and even bits read 0. Writes to 0x40 are ignored. Writes to 0x44 load the odd bits, subject to the R2 mask.
- R9: The group register reads 0 and ignores writes for a restricted access. Otherwise it is fully readable and writable.
- R10: The group-modifier and non-secure-access registers work only for a secure access while `sec_disable`=0. In all other cases they read 0 and ignore writes.
- R11: In the sleep register, bit 0 is the writable sleep request and bit 1 reads back the same value as a status bit. All other bits read 0.
- R12: A reserved offset reads 0, and a write to it changes no state.
- R13: Read data appears on `bus_rdata` at the clock edge that samples the read. It holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sec_disable | input | 1 | 1 = security disabled, every access unrestricted |
| bus_sel | input | 1 | Access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_size | input | 1 | 1 = 32-bit word, 0 = byte |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_secure | input | 1 | Secure attribute of the access |
| bus_rdata | output | 32 | Registered read data |
| irq_level | input | 32 | Raw input level of each private line |
| en_vec | output | 32 | Enable bits |
| pend_vec | output | 32 | Effective pending (latch OR level-triggered input) |
| act_vec | output | 32 | Active bits |
| prio_flat | output | 256 | Stored priorities, line n in bits 8n+7:8n |
| edge_vec | output | 32 | Edge-triggered flags |

## Verification
The checker assumes that word accesses use word-aligned offsets. It also assumes `bus_we` and `bus_size` are meaningful only while `bus_sel` is high, and that `sec_disable` changes only between accesses. The stimulus keeps to these rules. Every word access it issues is aligned, and it changes `sec_disable` and `irq_level` only on falling edges when no access is in flight. Interrupt input edges are spaced at least one cycle apart, so each rising edge is seen as a separate event.

// File: rtl/priv_irq_pkg.sv
package priv_irq_pkg;

  localparam int unsigned DATA_W = 32;
  localparam int unsigned PRIO_W = 8;
  localparam int unsigned OFFS_W = 8;

  localparam logic [OFFS_W-1:0] OFF_SLEEP  = 8'h00;
  localparam logic [OFFS_W-1:0] OFF_GROUP  = 8'h04;
  localparam logic [OFFS_W-1:0] OFF_EN_SET = 8'h08;
  localparam logic [OFFS_W-1:0] OFF_EN_CLR = 8'h0C;
  localparam logic [OFFS_W-1:0] OFF_PD_SET = 8'h10;
  localparam logic [OFFS_W-1:0] OFF_PD_CLR = 8'h14;
  localparam logic [OFFS_W-1:0] OFF_AC_SET = 8'h18;
  localparam logic [OFFS_W-1:0] OFF_AC_CLR = 8'h1C;
  localparam logic [OFFS_W-1:0] OFF_PRIO   = 8'h20;
  localparam logic [OFFS_W-1:0] OFF_CFG_LO = 8'h40;
  localparam logic [OFFS_W-1:0] OFF_CFG_HI = 8'h44;
  localparam logic [OFFS_W-1:0] OFF_GMOD   = 8'h48;
  localparam logic [OFFS_W-1:0] OFF_NSAC   = 8'h4C;

  typedef struct packed {
    logic sleep;
    logic group;
    logic en_set;
    logic en_clr;
    logic pd_set;
    logic pd_clr;
    logic ac_set;
    logic ac_clr;
    logic prio;
    logic cfg_lo;
    logic cfg_hi;
    logic gmod;
    logic nsac;
  } hit_t;

  // restricted view of a stored priority
  function automatic logic [PRIO_W-1:0] ns_prio_read(input logic [PRIO_W-1:0] p);
    return {p[PRIO_W-2:0], 1'b0};
  endfunction

  // stored value for a restricted priority write
  function automatic logic [PRIO_W-1:0] ns_prio_write(input logic [PRIO_W-1:0] v);
    return {1'b1, v[PRIO_W-1:1]};
  endfunction

  // place 16 flags into the odd bits of a word
  function automatic logic [DATA_W-1:0] spread_odd(input logic [DATA_W/2-1:0] h);
    logic [DATA_W-1:0] r;
    r = '0;
    for (int k = 0; k < DATA_W/2; k++) r[2*k+1] = h[k];
    return r;
  endfunction

  // collect the odd bits of a word
  function automatic logic [DATA_W/2-1:0] gather_odd(input logic [DATA_W-1:0] w);
    logic [DATA_W/2-1:0] r;
    for (int k = 0; k < DATA_W/2; k++) r[k] = w[2*k+1];
    return r;
  endfunction

endpackage

// File: rtl/priv_irq_decode.sv
module priv_irq_decode
  import priv_irq_pkg::*;
(
  input  logic [OFFS_W-1:0] addr,
  input  logic              size_word,
  output hit_t              hit
);

  localparam logic [OFFS_W-1:0] PRIO_SPAN_MASK = OFFS_W'(32 - 1);

  logic aligned;
  assign aligned = (addr[1:0] == 2'b00);

  always_comb begin
    hit = '0;
    if (size_word && aligned) begin
      case (addr)
        OFF_SLEEP:  hit.sleep  = 1'b1;
        OFF_GROUP:  hit.group  = 1'b1;
        OFF_EN_SET: hit.en_set = 1'b1;
        OFF_EN_CLR: hit.en_clr = 1'b1;
        OFF_PD_SET: hit.pd_set = 1'b1;
        OFF_PD_CLR: hit.pd_clr = 1'b1;
        OFF_AC_SET: hit.ac_set = 1'b1;
        OFF_AC_CLR: hit.ac_clr = 1'b1;
        OFF_CFG_LO: hit.cfg_lo = 1'b1;
        OFF_CFG_HI: hit.cfg_hi = 1'b1;
        OFF_GMOD:   hit.gmod   = 1'b1;
        OFF_NSAC:   hit.nsac   = 1'b1;
        default: ;
      endcase
    end
    if (((addr & ~PRIO_SPAN_MASK) == OFF_PRIO) && (!size_word || aligned))
      hit.prio = 1'b1;
  end

endmodule

// File: rtl/priv_irq_bitbank.sv
module priv_irq_bitbank #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_we,
  input  logic             clr_we,
  input  logic [WIDTH-1:0] wmask,
  input  logic [WIDTH-1:0] hw_set,
  output logic [WIDTH-1:0] state
);

  logic [WIDTH-1:0] set_bits;
  logic [WIDTH-1:0] clr_bits;
  logic [WIDTH-1:0] next_state;

  assign set_bits   = set_we ? wmask : '0;
  assign clr_bits   = clr_we ? wmask : '0;
  // hardware events are applied after a software clear
  assign next_state = ((state | set_bits) & ~clr_bits) | hw_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= '0;
    else        state <= next_state;
  end

endmodule

// File: rtl/priv_irq_prio_bank.sv
module priv_irq_prio_bank
  import priv_irq_pkg::*;
#(
  parameter int unsigned NUM = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic                  size_word,
  input  logic [$clog2(NUM)-1:0] idx,
  input  logic [DATA_W-1:0]     wdata,
  input  logic                  ns_restr,
  input  logic [NUM-1:0]        grp,
  output logic [DATA_W-1:0]     rd_word,
  output logic [NUM*PRIO_W-1:0] prio_flat
);

  localparam int unsigned IDX_W  = $clog2(NUM);
  localparam int unsigned LANES  = DATA_W / PRIO_W;
  localparam int unsigned LANE_W = $clog2(LANES);

  logic [PRIO_W-1:0] prio_q [NUM];
  logic [PRIO_W-1:0] view   [NUM];

  for (genvar i = 0; i < NUM; i++) begin : g_line
    localparam logic [IDX_W-1:0] ID = IDX_W'(i);
    logic              sel_i;
    logic              ok_i;
    logic [PRIO_W-1:0] in_i;

    assign sel_i = size_word ? (idx[IDX_W-1:LANE_W] == ID[IDX_W-1:LANE_W])
                             : (idx == ID);
    assign in_i  = size_word ? wdata[(i % LANES)*PRIO_W +: PRIO_W]
                             : wdata[PRIO_W-1:0];
    assign ok_i  = !ns_restr || grp[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        prio_q[i] <= '0;
      else if (wr_en && sel_i && ok_i)
        prio_q[i] <= ns_restr ? ns_prio_write(in_i) : in_i;
    end

    assign view[i] = !ns_restr ? prio_q[i]
                   : (grp[i] ? ns_prio_read(prio_q[i]) : '0);
    assign prio_flat[i*PRIO_W +: PRIO_W] = prio_q[i];
  end

  always_comb begin
    rd_word = '0;
    if (size_word) begin
      for (int l = 0; l < LANES; l++)
        rd_word[l*PRIO_W +: PRIO_W] = view[{idx[IDX_W-1:LANE_W], LANE_W'(l)}];
    end else begin
      rd_word[PRIO_W-1:0] = view[idx];
    end
  end

endmodule

// File: rtl/priv_irq_regfile.sv
module priv_irq_regfile
  import priv_irq_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      sec_disable,
  input  logic                      bus_sel,
  input  logic                      bus_we,
  input  logic                      bus_size,
  input  logic [OFFS_W-1:0]         bus_addr,
  input  logic [DATA_W-1:0]         bus_wdata,
  input  logic                      bus_secure,
  output logic [DATA_W-1:0]         bus_rdata,
  input  logic [NUM_IRQ-1:0]        irq_level,
  output logic [NUM_IRQ-1:0]        en_vec,
  output logic [NUM_IRQ-1:0]        pend_vec,
  output logic [NUM_IRQ-1:0]        act_vec,
  output logic [NUM_IRQ*PRIO_W-1:0] prio_flat,
  output logic [NUM_IRQ-1:0]        edge_vec
);

  localparam int unsigned HALF  = NUM_IRQ / 2;
  localparam int unsigned IDX_W = $clog2(NUM_IRQ);

  hit_t                hit;
  logic                wr;
  logic                rd;
  logic                restr;     // non-secure access while security enabled
  logic                sec_only;  // secure access while security enabled
  logic [NUM_IRQ-1:0]  gmask;
  logic [NUM_IRQ-1:0]  wbits;
  logic [NUM_IRQ-1:0]  grp_q;
  logic [NUM_IRQ-1:0]  gmod_q;
  logic [DATA_W-1:0]   nsac_q;
  logic [HALF-1:0]     edge_hi_q;
  logic [NUM_IRQ-1:0]  edge_full;
  logic                sleep_q;
  logic [NUM_IRQ-1:0]  level_q;
  logic [NUM_IRQ-1:0]  rise;
  logic [NUM_IRQ-1:0]  en_q;
  logic [NUM_IRQ-1:0]  pd_q;
  logic [NUM_IRQ-1:0]  ac_q;
  logic [NUM_IRQ-1:0]  pend_view;
  logic [DATA_W-1:0]   prio_rd;
  logic [DATA_W-1:0]   rd_val;
  logic [DATA_W-1:0]   rdata_q;

  priv_irq_decode u_dec (
    .addr      (bus_addr),
    .size_word (bus_size),
    .hit       (hit)
  );

  assign wr       = bus_sel && bus_we;
  assign rd       = bus_sel && !bus_we;
  assign restr    = !sec_disable && !bus_secure;
  assign sec_only = !sec_disable && bus_secure;
  assign gmask    = restr ? grp_q : '1;
  assign wbits    = bus_wdata[NUM_IRQ-1:0] & gmask;

  assign edge_full = {edge_hi_q, {HALF{1'b1}}};
  assign rise      = irq_level & ~level_q & edge_full;

  priv_irq_bitbank #(.WIDTH(NUM_IRQ)) u_en (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_we (wr && hit.en_set),
    .clr_we (wr && hit.en_clr),
    .wmask  (wbits),
    .hw_set ('0),
    .state  (en_q)
  );

  priv_irq_bitbank #(.WIDTH(NUM_IRQ)) u_pd (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_we (wr && hit.pd_set),
    .clr_we (wr && hit.pd_clr),
    .wmask  (wbits),
    .hw_set (rise),
    .state  (pd_q)
  );

  priv_irq_bitbank #(.WIDTH(NUM_IRQ)) u_ac (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_we (wr && hit.ac_set),
    .clr_we (wr && hit.ac_clr),
    .wmask  (wbits),
    .hw_set ('0),
    .state  (ac_q)
  );

  priv_irq_prio_bank #(.NUM(NUM_IRQ)) u_prio (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr && hit.prio),
    .size_word (bus_size),
    .idx       (bus_addr[IDX_W-1:0]),
    .wdata     (bus_wdata),
    .ns_restr  (restr),
    .grp       (grp_q),
    .rd_word   (prio_rd),
    .prio_flat (prio_flat)
  );

  assign pend_view = pd_q | (~edge_full & irq_level);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp_q     <= '0;
      gmod_q    <= '0;
      nsac_q    <= '0;
      edge_hi_q <= '0;
      sleep_q   <= 1'b0;
      level_q   <= '0;
    end else begin
      level_q <= irq_level;
      if (wr && hit.group && !restr)
        grp_q <= bus_wdata[NUM_IRQ-1:0];
      if (wr && hit.gmod && sec_only)
        gmod_q <= bus_wdata[NUM_IRQ-1:0];
      if (wr && hit.nsac && sec_only)
        nsac_q <= bus_wdata;
      if (wr && hit.cfg_hi)
        edge_hi_q <= (edge_hi_q & ~gmask[NUM_IRQ-1:HALF])
                   | (gather_odd(bus_wdata) & gmask[NUM_IRQ-1:HALF]);
      if (wr && hit.sleep)
        sleep_q <= bus_wdata[0];
    end
  end

  always_comb begin
    rd_val = '0;
    if (hit.sleep)                   rd_val = {{(DATA_W-2){1'b0}}, sleep_q, sleep_q};
    if (hit.group)                   rd_val = restr ? '0 : grp_q;
    if (hit.en_set || hit.en_clr)    rd_val = en_q & gmask;
    if (hit.pd_set || hit.pd_clr)    rd_val = pend_view & gmask;
    if (hit.ac_set || hit.ac_clr)    rd_val = ac_q & gmask;
    if (hit.prio)                    rd_val = prio_rd;
    if (hit.cfg_lo)                  rd_val = spread_odd(edge_full[HALF-1:0] & gmask[HALF-1:0]);
    if (hit.cfg_hi)                  rd_val = spread_odd(edge_full[NUM_IRQ-1:HALF] & gmask[NUM_IRQ-1:HALF]);
    if (hit.gmod)                    rd_val = sec_only ? gmod_q : '0;
    if (hit.nsac)                    rd_val = sec_only ? nsac_q : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata_q <= '0;
    else if (rd) rdata_q <= rd_val;
  end

  assign bus_rdata = rdata_q;
  assign en_vec    = en_q;
  assign pend_vec  = pend_view;
  assign act_vec   = ac_q;
  assign edge_vec  = edge_full;

endmodule

// File: rtl/priv_irq_regfile_chk.sv
module priv_irq_regfile_chk
  import priv_irq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              sec_disable,
  input logic              bus_sel,
  input logic              bus_we,
  input logic              bus_size,
  input logic [OFFS_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_secure,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [31:0]       en_vec,
  input logic [31:0]       edge_vec,
  input logic [31:0]       grp,
  input logic              sleep
);

  logic wr_word;
  assign wr_word = bus_sel && bus_we && bus_size;

  // R2
  ns_enmask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_word && bus_addr == OFF_EN_SET && !sec_disable && !bus_secure)
    |=> ((en_vec & ~$past(grp)) == ($past(en_vec) & ~$past(grp))));

  // R3
  set_noclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_word && bus_addr == OFF_EN_SET) |=> (($past(en_vec) & ~en_vec) == '0));

  // R3
  clr_noset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_word && bus_addr == OFF_EN_CLR) |=> ((en_vec & ~$past(en_vec)) == '0));

  // R8
  cfglo_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_word && bus_addr == OFF_CFG_LO) |=> $stable(edge_vec));

  // R11
  sleep_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_word && bus_addr == OFF_SLEEP) |=> (sleep == $past(bus_wdata[0])));

  // R13
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && !bus_we) |=> $stable(bus_rdata));

endmodule

bind priv_irq_regfile priv_irq_regfile_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sec_disable (sec_disable),
  .bus_sel     (bus_sel),
  .bus_we      (bus_we),
  .bus_size    (bus_size),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata),
  .bus_secure  (bus_secure),
  .bus_rdata   (bus_rdata),
  .en_vec      (en_vec),
  .edge_vec    (edge_vec),
  .grp         (grp_q),
  .sleep       (sleep_q)
);

// File: tb/priv_irq_regfile_bench.sv
`timescale 1ns/1ps
module priv_irq_regfile_bench;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         sec_disable = 1'b0;
  logic         bus_sel = 1'b0;
  logic         bus_we = 1'b0;
  logic         bus_size = 1'b1;
  logic [7:0]   bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic         bus_secure = 1'b1;
  logic [31:0]  bus_rdata;
  logic [31:0]  irq_level = '0;
  logic [31:0]  en_vec, pend_vec, act_vec, edge_vec;
  logic [255:0] prio_flat;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_q [$];
  string       tag_q [$];
  logic        rd_seen = 1'b0;

  always #2 clk = ~clk;

  priv_irq_regfile u_priv_irq_regfile (
    .clk(clk), .rst_n(rst_n), .sec_disable(sec_disable),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_size(bus_size),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_secure(bus_secure),
    .bus_rdata(bus_rdata), .irq_level(irq_level),
    .en_vec(en_vec), .pend_vec(pend_vec), .act_vec(act_vec),
    .prio_flat(prio_flat), .edge_vec(edge_vec)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compares each read result against the scoreboard queue
  always @(posedge clk) rd_seen <= rst_n && bus_sel && !bus_we;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) check(bus_rdata, 32'hDEAD_BEEF, "unexpected read");
      else check(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic sec, input logic word = 1'b1);
    bus_sel = 1'b1; bus_we = 1'b1; bus_size = word; bus_addr = a; bus_wdata = d; bus_secure = sec;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic sec, input logic [31:0] exp, input string tag,
                    input logic word = 1'b1);
    bus_sel = 1'b1; bus_we = 1'b0; bus_size = word; bus_addr = a; bus_secure = sec;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(bus_rdata, 32'h0, "R1 rdata");
    check(edge_vec, 32'h0000_FFFF, "R1 edge_vec");
    check(pend_vec, 32'h0, "R1 pend_vec");
    rd(8'h00, 1'b1, 32'h0, "R1 sleep reg");
    rd(8'h08, 1'b1, 32'h0, "R1 enable");

    // R9 group register
    wr(8'h04, 32'h0000_FF00, 1'b1);
    rd(8'h04, 1'b0, 32'h0, "R9 ns group read");
    wr(8'h04, 32'hFFFF_FFFF, 1'b0);
    rd(8'h04, 1'b1, 32'h0000_FF00, "R9 group after ns write");

    // R2 R3 enable set/clear
    wr(8'h08, 32'hFFFF_FFFF, 1'b0);
    check(en_vec, 32'h0000_FF00, "R2 ns enable set masked");
    wr(8'h08, 32'h0000_0003, 1'b1);
    check(en_vec, 32'h0000_FF03, "R3 set ORs");
    rd(8'h0C, 1'b0, 32'h0000_FF00, "R3 ns clear-offset read masked");
    wr(8'h0C, 32'h0000_0101, 1'b1);
    check(en_vec, 32'h0000_FE02, "R3 clear");
    wr(8'h0C, 32'hFFFF_FFFF, 1'b0);
    check(en_vec, 32'h0000_0002, "R2 ns clear masked");

    // active bank
    wr(8'h18, 32'h8000_0001, 1'b1);
    wr(8'h1C, 32'hFFFF_FFFF, 1'b0);
    check(act_vec, 32'h8000_0001, "R2 ns active clear ignored");

    // R8 trigger configuration
    wr(8'h44, 32'h0000_0002, 1'b1);
    check(edge_vec, 32'h0001_FFFF, "R8 cfg hi write");
    wr(8'h44, 32'hFFFF_FFFF, 1'b0);
    check(edge_vec, 32'h0001_FFFF, "R2 ns cfg hi masked");
    rd(8'h44, 1'b1, 32'h0000_0002, "R8 cfg hi read");
    rd(8'h40, 1'b1, 32'hAAAA_AAAA, "R8 cfg lo read");
    rd(8'h40, 1'b0, 32'hAAAA_0000, "R8 ns cfg lo read");
    wr(8'h40, 32'h0, 1'b1);
    check(edge_vec, 32'h0001_FFFF, "R8 cfg lo write ignored");

    // R4 level-triggered pending view
    irq_level = 32'h0010_0000;
    @(negedge clk);
    check(pend_vec, 32'h0010_0000, "R4 level pend_vec");
    rd(8'h10, 1'b1, 32'h0010_0000, "R4 level pend read");
    rd(8'h10, 1'b0, 32'h0, "R2 ns pend read masked");
    irq_level = 32'h0;
    @(negedge clk);
    check(pend_vec, 32'h0, "R4 level drop");

    // R5 edge latch
    irq_level = 32'h0001_0000;
    @(negedge clk);
    check(pend_vec, 32'h0001_0000, "R5 edge latched");
    irq_level = 32'h0;
    @(negedge clk);
    check(pend_vec, 32'h0001_0000, "R5 latch holds");
    wr(8'h14, 32'h0001_0000, 1'b1);
    check(pend_vec, 32'h0, "R5 clear latch");

    // R6 R7 priorities
    wr(8'h29, 32'h40, 1'b1, 1'b0);
    rd(8'h29, 1'b0, 32'h80, "R6 ns view read", 1'b0);
    wr(8'h29, 32'h10, 1'b0, 1'b0);
    check({24'h0, prio_flat[9*8 +: 8]}, 32'h88, "R6 ns write stores");
    wr(8'h22, 32'h77, 1'b0, 1'b0);
    rd(8'h22, 1'b1, 32'h0, "R6 group0 ns write ignored", 1'b0);
    rd(8'h22, 1'b0, 32'h0, "R6 group0 ns read zero", 1'b0);
    wr(8'h24, 32'h4433_2211, 1'b1);
    rd(8'h24, 1'b1, 32'h4433_2211, "R7 word read");
    check({24'h0, prio_flat[6*8 +: 8]}, 32'h33, "R7 lane order");
    rd(8'h28, 1'b0, 32'h0000_1000, "R7 ns word read");
    rd(8'h08, 1'b1, 32'h0, "R7 byte access off priority", 1'b0);
    wr(8'h08, 32'hFF, 1'b1, 1'b0);
    check(en_vec, 32'h0000_0002, "R7 byte write ignored");

    // R10 modifier and access-control words
    wr(8'h48, 32'h0000_ABCD, 1'b1);
    rd(8'h48, 1'b1, 32'h0000_ABCD, "R10 gmod secure");
    rd(8'h48, 1'b0, 32'h0, "R10 gmod ns read");
    wr(8'h48, 32'h0000_1111, 1'b0);
    rd(8'h48, 1'b1, 32'h0000_ABCD, "R10 gmod ns write ignored");
    wr(8'h4C, 32'h0000_0005, 1'b1);
    rd(8'h4C, 1'b1, 32'h0000_0005, "R10 nsac secure");

    // security disabled
    sec_disable = 1'b1;
    @(negedge clk);
    rd(8'h48, 1'b1, 32'h0, "R10 gmod with security off");
    wr(8'h08, 32'h0000_0001, 1'b0);
    check(en_vec, 32'h0000_0003, "R2 unrestricted set");
    rd(8'h04, 1'b0, 32'h0000_FF00, "R9 group unrestricted");
    wr(8'h22, 32'h77, 1'b0, 1'b0);
    rd(8'h22, 1'b0, 32'h77, "R6 raw view with security off", 1'b0);
    sec_disable = 1'b0;
    @(negedge clk);

    // R11 sleep handshake
    wr(8'h00, 32'hFFFF_FFFF, 1'b1);
    rd(8'h00, 1'b1, 32'h3, "R11 sleep set");
    wr(8'h00, 32'h0, 1'b1);
    rd(8'h00, 1'b1, 32'h0, "R11 sleep clear");

    // R12 reserved
    wr(8'h80, 32'hFFFF_FFFF, 1'b1);
    rd(8'h80, 1'b1, 32'h0, "R12 reserved read");
    rd(8'h08, 1'b1, 32'h0000_0003, "R12 state untouched");

    // R13 hold
    rd(8'h04, 1'b1, 32'h0000_FF00, "R13 read");
    @(negedge clk);
    check(bus_rdata, 32'h0000_FF00, "R13 hold when idle");
    wr(8'h04, 32'h0000_0000, 1'b1);
    check(bus_rdata, 32'h0000_FF00, "R13 hold over write");

    @(negedge clk);
    if (exp_q.size() != 0) check(32'(exp_q.size()), 32'h0, "scoreboard drained");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule